// File: doc/BRIEF.md
# Receive Frame-Sync and Start Controller

This block decides when a synchronous serial receiver begins and ends capturing data words, and it produces a periodic frame-sync pulse derived from the receive bit clock. It runs on one system clock and moves forward only on cycles where the receive clock enable tick is high. The receive clock is supplied as that tick. The shifter, the compare-pattern matcher and the clock selection sit outside the block. They deliver strobes to it: a generic start event, a transmitter-start event, compare-0 and compare-1 matches, and a word-done strobe at the end of each received word.

Software loads four settings in one write cycle: a period divider, a start delay, a stop mode and a start source. After a trigger is accepted, the controller counts the programmed number of ticks and then raises the receive-active flag. While that flag is high, the data-capture enable follows the tick. Depending on the stop mode, reception ends either at the next word-done or at a compare-1 match. The frame-sync generator runs independently of the start and stop logic. When the period field is written, its divider restarts.

Top module: `rxfs_ctrl`

## Requirements
- R1: All configuration fields are zero after reset and are loaded together in a cycle where `cfg_wr` is high. Start source code 0 never starts reception, so after reset `rx_active`, `capture_en` and `fsync_out` all stay low.
- R2: While the stored period field is zero, `fsync_out` stays low.
- R3: Take a nonzero stored period P. `fsync_out` goes high after every 2×(P+1)-th tick counted from the configuration write, and it stays high only until the following tick. A new configuration write restarts this count.
- R4: Take a start delay D. If D is zero, `rx_active` rises after the tick on which the trigger was accepted. If D is nonzero, it rises after the D-th later tick.
- R5: Start source codes are 1 for `start_evt`, 2 for `txsync_evt` and 3 for `cmp0_hit`. A strobe from a source that is not selected has no effect. The start delay applies to every source.
- R6: With `cfg_hold_cmp1` set to 1, reception stays active through `word_done` strobes and ends on a tick that carries `cmp1_hit`.
- R7: With `cfg_hold_cmp1` set to 0, reception ends on a tick that carries `word_done`. `cmp1_hit` is ignored while active and while idle. A later compare-0 trigger starts reception again.
- R8: `capture_en` is high exactly when `rx_active` and `rx_tick` are both high.
- R9: Strobes on cycles without `rx_tick` have no effect, and state changes only on tick cycles.
- R10: A trigger that arrives while a start delay is counting down, or while reception is active, is ignored. The countdown keeps its original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Receive clock enable tick |
| start_evt | input | 1 | Generic start event strobe |
| txsync_evt | input | 1 | Start-with-transmitter strobe |
| cmp0_hit | input | 1 | Compare-0 match strobe |
| cmp1_hit | input | 1 | Compare-1 match strobe |
| word_done | input | 1 | End of one received data word |
| cfg_wr | input | 1 | Load all configuration fields |
| cfg_period | input | 8 | Frame-sync period divider |
| cfg_delay | input | 8 | Start delay in ticks |
| cfg_hold_cmp1 | input | 1 | Stop mode: 1 = run until compare-1, 0 = one word |
| cfg_src | input | 2 | Start source select |
| fsync_out | output | 1 | Periodic frame-sync pulse |
| rx_active | output | 1 | Reception active flag |
| capture_en | output | 1 | Data-capture enable |

## Verification
The hardest case to reach from the ports is a fresh trigger landing in the middle of a start-delay countdown, with tick-free cycles mixed in. Moving the countdown one tick early or late in that case is what exposes a delay counter that reloads or miscounts. The bench reaches it with a per-cycle task that drives every strobe independently of the tick. That task places a repeat trigger and a gap cycle inside the countdown, then samples `rx_active` after each edge to find the exact tick on which it rises. The frame-sync divider is exercised from a vector table of periods. For each period the bench measures the first interval, the repeat interval and the pulse count over a fixed window, and it also rewrites the period partway through a cycle.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;

    localparam int PERIOD_W = 8;
    localparam int DELAY_W  = 8;
    localparam int SRC_W    = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE   = 2'd0,
        SRC_EVENT  = 2'd1,
        SRC_TXSYNC = 2'd2,
        SRC_CMP0   = 2'd3
    } start_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [DELAY_W-1:0]  delay;
        logic                hold_to_cmp1;
        start_src_e          src;
    } rx_cfg_t;

    typedef struct packed {
        logic tick;
        logic start;
        logic txsync;
        logic cmp0;
        logic cmp1;
        logic word_done;
    } rx_evt_t;

    // True when the selected trigger source fires in this event bundle.
    function automatic logic src_fire(input start_src_e s, input rx_evt_t e);
        logic hit;
        case (s)
            SRC_EVENT:  hit = e.start;
            SRC_TXSYNC: hit = e.txsync;
            SRC_CMP0:   hit = e.cmp0;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Stop condition for the running state under the chosen stop mode.
    function automatic logic stop_hit(input logic hold, input rx_evt_t e);
        return hold ? e.cmp1 : e.word_done;
    endfunction

endpackage

// File: rtl/rxfs_cfg_regs.sv
module rxfs_cfg_regs
    import rxfs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr,
    input  rx_cfg_t cfg_in,
    output rx_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/rxfs_fsync_gen.sv
module rxfs_fsync_gen #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic [PW-1:0] period,
    output logic          pulse
);

    localparam int CW = PW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Last count of a 2*(P+1) tick cycle is 2P+1.
    assign last = {period, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (period == '0) begin
                cnt   <= '0;
                pulse <= 1'b0;
            end else if (cnt == last) begin
                cnt   <= '0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + CW'(1);
                pulse <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxfs_start_ctl.sv
module rxfs_start_ctl
    import rxfs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  rx_evt_t       evt,
    input  start_src_e    src,
    input  logic [DW-1:0] delay,
    input  logic          hold_to_cmp1,
    output logic          active
);

    seq_state_e    state, state_nx;
    logic [DW-1:0] cnt, cnt_nx;
    logic          fire;
    logic          stop;

    assign fire = src_fire(src, evt);
    assign stop = stop_hit(hold_to_cmp1, evt);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (evt.tick) begin
            case (state)
                ST_IDLE: begin
                    if (fire) begin
                        if (delay == '0) begin
                            state_nx = ST_RUN;
                        end else begin
                            state_nx = ST_DELAY;
                            cnt_nx   = delay;
                        end
                    end
                end
                ST_DELAY: begin
                    if (cnt == DW'(1)) begin
                        state_nx = ST_RUN;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt - DW'(1);
                    end
                end
                ST_RUN: begin
                    if (stop) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign active = (state == ST_RUN);

endmodule

// File: rtl/rxfs_ctrl.sv
module rxfs_ctrl
    import rxfs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_tick,
    input  logic                start_evt,
    input  logic                txsync_evt,
    input  logic                cmp0_hit,
    input  logic                cmp1_hit,
    input  logic                word_done,
    input  logic                cfg_wr,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [DELAY_W-1:0]  cfg_delay,
    input  logic                cfg_hold_cmp1,
    input  logic [SRC_W-1:0]    cfg_src,
    output logic                fsync_out,
    output logic                rx_active,
    output logic                capture_en
);

    rx_cfg_t cfg_in;
    rx_cfg_t cfg_q;
    rx_evt_t evt;

    assign cfg_in.period       = cfg_period;
    assign cfg_in.delay        = cfg_delay;
    assign cfg_in.hold_to_cmp1 = cfg_hold_cmp1;
    assign cfg_in.src          = start_src_e'(cfg_src);

    assign evt.tick      = rx_tick;
    assign evt.start     = start_evt;
    assign evt.txsync    = txsync_evt;
    assign evt.cmp0      = cmp0_hit;
    assign evt.cmp1      = cmp1_hit;
    assign evt.word_done = word_done;

    rxfs_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    rxfs_fsync_gen #(.PW(PERIOD_W)) u_fsync (
        .clk     (clk),
        .rst     (rst),
        .tick    (rx_tick),
        .restart (cfg_wr),
        .period  (cfg_q.period),
        .pulse   (fsync_out)
    );

    rxfs_start_ctl #(.DW(DELAY_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .src          (cfg_q.src),
        .delay        (cfg_q.delay),
        .hold_to_cmp1 (cfg_q.hold_to_cmp1),
        .active       (rx_active)
    );

    assign capture_en = rx_active & rx_tick;

endmodule

// File: rtl/rxfs_ctrl_chk.sv
module rxfs_ctrl_chk
    import rxfs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                rx_tick,
    input logic                cmp1_hit,
    input logic                word_done,
    input logic                fsync_out,
    input logic                rx_active,
    input logic                capture_en,
    input logic [PERIOD_W-1:0] period_q,
    input logic                hold_q
);

    // R8
    assert_capture_gated_R8: assert property (@(posedge clk) disable iff (rst)
        capture_en |-> (rx_active && rx_tick));

    // R2
    assert_no_fsync_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (period_q == '0) |=> !fsync_out);

    // R3
    assert_fsync_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync_out) |-> $past(rx_tick));

    // R9
    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_tick |=> $stable(rx_active));

    // R7
    assert_cmp1_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_active && !hold_q && rx_tick && cmp1_hit && !word_done) |=> rx_active);

endmodule

bind rxfs_ctrl rxfs_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_tick    (rx_tick),
    .cmp1_hit   (cmp1_hit),
    .word_done  (word_done),
    .fsync_out  (fsync_out),
    .rx_active  (rx_active),
    .capture_en (capture_en),
    .period_q   (cfg_q.period),
    .hold_q     (cfg_q.hold_to_cmp1)
);

// File: tb/sim_rxfs_ctrl.sv
module sim_rxfs_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    localparam int VP [NV] = '{1, 2, 5, 0, 9};
    localparam int VG [NV] = '{4, 6, 12, 0, 20};
    localparam int WIN = 60;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 0, start_evt = 0, txsync_evt = 0;
    logic       cmp0_hit = 0, cmp1_hit = 0, word_done = 0;
    logic       cfg_wr = 0;
    logic [7:0] cfg_period = 0, cfg_delay = 0;
    logic       cfg_hold_cmp1 = 0;
    logic [1:0] cfg_src = 0;
    logic       fsync_out, rx_active, capture_en;

    int n_chk = 0;
    int n_fail = 0;

    rxfs_ctrl u0 (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .start_evt(start_evt),
        .txsync_evt(txsync_evt), .cmp0_hit(cmp0_hit), .cmp1_hit(cmp1_hit),
        .word_done(word_done), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .cfg_delay(cfg_delay), .cfg_hold_cmp1(cfg_hold_cmp1), .cfg_src(cfg_src),
        .fsync_out(fsync_out), .rx_active(rx_active), .capture_en(capture_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // One clock cycle with the given strobes; sampled 1ns after the edge.
    task automatic cyc(input logic t, input logic s, input logic x,
                       input logic c0, input logic c1, input logic wd);
        rx_tick = t; start_evt = s; txsync_evt = x;
        cmp0_hit = c0; cmp1_hit = c1; word_done = wd;
        @(posedge clk);
        #1;
        rx_tick = 0; start_evt = 0; txsync_evt = 0;
        cmp0_hit = 0; cmp1_hit = 0; word_done = 0;
    endtask

    task automatic wcfg(input int p, input int d, input logic h, input int s);
        cfg_wr = 1; cfg_period = 8'(p); cfg_delay = 8'(d);
        cfg_hold_cmp1 = h; cfg_src = 2'(s);
        @(posedge clk);
        #1;
        cfg_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        int first, second, highs;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;

        // R1: reset state and source 0 never starts
        chk("R1 rx_active after reset", int'(rx_active), 0);
        chk("R1 fsync after reset", int'(fsync_out), 0);
        chk("R1 capture after reset", int'(capture_en), 0);
        for (int k = 0; k < 4; k++) cyc(1, 1, 1, 1, 0, 0);
        chk("R1 default source stays idle", int'(rx_active), 0);

        // R2/R3: frame-sync period table
        for (int i = 0; i < NV; i++) begin
            wcfg(VP[i], 0, 0, 0);
            first = 0; second = 0; highs = 0;
            for (int k = 1; k <= WIN; k++) begin
                cyc(1, 0, 0, 0, 0, 0);
                if (fsync_out) begin
                    highs++;
                    if (first == 0) first = k;
                    else if (second == 0) second = k;
                end
            end
            chk(VP[i] == 0 ? "R2 no pulse first" : "R3 first pulse tick", first, VG[i]);
            chk(VP[i] == 0 ? "R2 no pulse gap" : "R3 pulse interval", second - first, VG[i]);
            chk(VP[i] == 0 ? "R2 pulse count" : "R3 one-tick width count", highs,
                VG[i] == 0 ? 0 : WIN / VG[i]);
        end

        // R3: rewrite restarts divider
        wcfg(1, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0, 0);
        wcfg(1, 0, 0, 0);
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            cyc(1, 0, 0, 0, 0, 0);
            if (fsync_out && first == 0) first = k;
        end
        chk("R3 restart on write", first, 4);

        // R9: no tick, no effect; R4 zero delay
        wcfg(0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R9 start without tick ignored", int'(rx_active), 0);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R4 zero delay starts at trigger tick", int'(rx_active), 1);
        // R8: capture follows tick while active
        rx_tick = 1; #1;
        chk("R8 capture with tick", int'(capture_en), 1);
        rx_tick = 0; #1;
        chk("R8 capture without tick", int'(capture_en), 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R9 word_done without tick ignored", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R7 word_done stops", int'(rx_active), 0);

        // R4/R10: delay 3 with repeat trigger and gap cycle
        wcfg(0, 3, 0, 1);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R4 delay not yet", int'(rx_active), 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R10 retrigger during delay ignored", int'(rx_active), 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R4 active after third tick", int'(rx_active), 1);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R10 trigger while active ignored", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R7 stop after delayed start", int'(rx_active), 0);

        // R5: transmitter source with delay 2
        wcfg(0, 2, 0, 2);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R5 unselected source ignored", int'(rx_active), 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R5 txsync delay pending", int'(rx_active), 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R5 txsync delayed start", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 0, 1);

        // R6: continuous until compare-1
        wcfg(0, 0, 1, 3);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R6 cmp0 starts", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R6 word_done does not stop", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R6 cmp1 stops", int'(rx_active), 0);

        // R7: single-word mode
        wcfg(0, 0, 0, 3);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R7 cmp1 idle ignored", int'(rx_active), 0);
        cyc(1, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 1, 0);
        chk("R7 cmp1 active ignored", int'(rx_active), 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R7 ends on word_done", int'(rx_active), 0);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R7 new cmp0 restarts", int'(rx_active), 1);

        report();
        $finish;
    end

endmodule